// File: doc/BRIEF.md
# Nonvolatile memory access controller

This block lets a CPU reach two memories through a small register window: a 256-byte data store that can be read and rewritten one byte at a time, and a 4K-word program store of 14-bit words that can only be read. The CPU selects a location through two address registers and moves data through two data registers. A control register selects the space, starts reads and writes, and holds the completion and error flags. An unlock register holds no data and gates write starts.

A read takes one clock to launch and one more clock to land in the data registers. A byte write first erases the location to 0xFF and then stores the new value after a programmable number of cycles. When the write ends, the block raises a sticky completion flag. A warm reset that lands mid-write aborts the write and records an error flag. The address and data registers keep their values through a warm reset, so software can retry the write. The program store is a computed read-only pattern. Nothing on the bus can alter it.

Top module: `nvm_ctrl`

## Requirements
- R1: Register offsets on `bus_addr` are as follows.
  - 0: address low.
  - 1: address high, bits 3:0 only; upper bits read 0.
  - 2: data low.
  - 3: data high, bits 5:0 only; upper bits read 0.
  - 4: control.
  - 5: unlock.
  - Control bits: 0 read-start, 1 write-start, 2 write-enable, 3 write-error, 4 write-done, 7 space-select (1 = program). Bits 6:5 read 0.
  - The unlock register and offsets 6 and 7 always read 0.
- R2: While `por_n` is low at a clock edge, every register clears to 0 and `done_irq` is 0.
- R3: Setting read-start with space-select 0 loads data low from the data byte at address low on the following edge, and read-start then reads 0. Data high is left unchanged.
- R4: Setting read-start with space-select 1 loads the program word at {address high, address low} into {data high, data low}. The word at address a is (a*467 + 677) mod 16384.
- R5: A write starts only when all of the following hold.
  - The unlock register receives 0x55 and then 0xAA on consecutive bus writes.
  - The very next bus write goes to control with bit 1 set, bit 2 set and bit 7 clear.
  - Any other bus write in between cancels the sequence.
- R6: A control write that lacks write-enable (bit 2) does not start a write, even right after the unlock pair.
- R7: A write request with space-select 1 never starts, and program contents stay as stated in R4.
- R8: Write-start reads 1 for exactly WR_CYCLES cycles. It then clears, and write-done and `done_irq` become 1.
- R9: At the write start the addressed byte becomes 0xFF. At completion it holds the data low value.
- R10: While read-start or write-start is set, every bus write is ignored. This includes the start bits, the address and data registers, and the unlock sequence.
- R11: Write-done and write-error change only by hardware setting them, by a CPU control write of the matching bit, or by a reset. Write-done stays set until then.
- R12: A warm reset (`warm_rst_n` low) during a write sets write-error and clears the other control bits. The addressed byte is left erased at 0xFF, and the address and data registers are kept.
- R13: A warm reset while idle keeps write-error, address and data unchanged and clears the other control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| warm_rst_n | input | 1 | Warm reset (pin or watchdog), synchronous, active low |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| done_irq | output | 1 | Write-complete interrupt, mirrors write-done |

## Verification
The bench builds the block with WR_CYCLES set to 5 and keeps the address and word widths at their defaults. The short write time lets the bench run many writes, including ones interrupted at chosen cycles and ones that collide with bus writes made during the busy window. With the full default widths, the bench can read the first and last program word and an interior word. It also checks that the address-high and data-high registers mask their unused bits.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    localparam logic [2:0] REG_ALO  = 3'd0;
    localparam logic [2:0] REG_AHI  = 3'd1;
    localparam logic [2:0] REG_DLO  = 3'd2;
    localparam logic [2:0] REG_DHI  = 3'd3;
    localparam logic [2:0] REG_CTRL = 3'd4;
    localparam logic [2:0] REG_ULK  = 3'd5;

    localparam int B_RD    = 0;
    localparam int B_WR    = 1;
    localparam int B_WREN  = 2;
    localparam int B_ERR   = 3;
    localparam int B_DONE  = 4;
    localparam int B_SPACE = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        ULK_IDLE  = 2'd0,
        ULK_HALF  = 2'd1,
        ULK_ARMED = 2'd2
    } ulk_state_t;
endpackage

// File: rtl/nvm_data_array.sv
module nvm_data_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/nvm_prog_rom.sv
module nvm_prog_rom #(
    parameter int AW = 12,
    parameter int W  = 14
) (
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  word
);
    localparam logic [31:0] MUL = 32'd467;
    localparam logic [31:0] OFS = 32'd677;

    logic [31:0] prod;

    assign prod = 32'(addr) * MUL + OFS;
    assign word = prod[W-1:0];
endmodule

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       we,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic       armed
);
    ulk_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ULK_IDLE;
        end else if (we) begin
            if (addr == REG_ULK && wdata == KEY_FIRST)
                state_d = ULK_HALF;
            else if (addr == REG_ULK && wdata == KEY_SECOND && state_q == ULK_HALF)
                state_d = ULK_ARMED;
            else
                state_d = ULK_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign armed = (state_q == ULK_ARMED);

    // R5: arming always follows the half-open state
    p_arm_from_half_r5: assert property (@(posedge clk) disable iff (clr)
        $rose(armed) |-> $past(state_q == ULK_HALF));
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int DATA_AW   = 8,
    parameter int PROG_AW   = 12,
    parameter int PROG_W    = 14,
    parameter int WR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       warm_rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       done_irq
);
    localparam int AHI_W = PROG_AW - 8;
    localparam int DHI_W = PROG_W - 8;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

    typedef struct packed {
        logic [7:0]       alo;
        logic [AHI_W-1:0] ahi;
        logic [7:0]       dlo;
        logic [DHI_W-1:0] dhi;
        logic             space;
        logic             wren;
        logic             err;
        logic             done;
        logic             rd_go;
        logic             wr_go;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t d, q;

    logic              busy;
    logic              armed;
    logic              ram_we;
    logic              ram_we_eff;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;
    logic [PROG_W-1:0] prog_word;
    logic              ulk_clr;
    logic [7:0]        ctrl_view;

    assign busy    = q.rd_go | q.wr_go;
    assign ulk_clr = !por_n || !warm_rst_n || busy;

    nvm_unlock u_unlock (
        .clk   (clk),
        .clr   (ulk_clr),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .armed (armed)
    );

    nvm_data_array #(.AW(DATA_AW)) u_data (
        .clk   (clk),
        .we    (ram_we_eff),
        .addr  (q.alo[DATA_AW-1:0]),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    nvm_prog_rom #(.AW(PROG_AW), .W(PROG_W)) u_prog (
        .addr (PROG_AW'({q.ahi, q.alo})),
        .word (prog_word)
    );

    always_comb begin
        d         = q;
        ram_we    = 1'b0;
        ram_wdata = 8'h00;
        if (q.wr_go) begin
            if (q.cnt == CNT_LAST) begin
                ram_we    = 1'b1;
                ram_wdata = q.dlo;
                d.wr_go   = 1'b0;
                d.done    = 1'b1;
                d.cnt     = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (q.rd_go) begin
            d.rd_go = 1'b0;
            if (q.space) {d.dhi, d.dlo} = prog_word;
            else         d.dlo = ram_rdata;
        end else if (bus_we) begin
            case (bus_addr)
                REG_ALO:  d.alo = bus_wdata;
                REG_AHI:  d.ahi = bus_wdata[AHI_W-1:0];
                REG_DLO:  d.dlo = bus_wdata;
                REG_DHI:  d.dhi = bus_wdata[DHI_W-1:0];
                REG_CTRL: begin
                    d.space = bus_wdata[B_SPACE];
                    d.wren  = bus_wdata[B_WREN];
                    d.err   = bus_wdata[B_ERR];
                    d.done  = bus_wdata[B_DONE];
                    if (armed && bus_wdata[B_WR] && bus_wdata[B_WREN] && !bus_wdata[B_SPACE]) begin
                        d.wr_go   = 1'b1;
                        d.cnt     = '0;
                        ram_we    = 1'b1;
                        ram_wdata = 8'hFF;
                    end else begin
                        d.rd_go = bus_wdata[B_RD];
                    end
                end
                default: ;
            endcase
        end
        if (!warm_rst_n) begin
            d       = q;
            d.err   = q.err | q.wr_go;
            d.space = 1'b0;
            d.wren  = 1'b0;
            d.done  = 1'b0;
            d.rd_go = 1'b0;
            d.wr_go = 1'b0;
            d.cnt   = '0;
            ram_we  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign ram_we_eff = ram_we & por_n;

    always_comb begin
        ctrl_view          = 8'h00;
        ctrl_view[B_RD]    = q.rd_go;
        ctrl_view[B_WR]    = q.wr_go;
        ctrl_view[B_WREN]  = q.wren;
        ctrl_view[B_ERR]   = q.err;
        ctrl_view[B_DONE]  = q.done;
        ctrl_view[B_SPACE] = q.space;
    end

    always_comb begin
        case (bus_addr)
            REG_ALO:  bus_rdata = q.alo;
            REG_AHI:  bus_rdata = 8'(q.ahi);
            REG_DLO:  bus_rdata = q.dlo;
            REG_DHI:  bus_rdata = 8'(q.dhi);
            REG_CTRL: bus_rdata = ctrl_view;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign done_irq = q.done;

    // R5: a write only begins from an armed unlock state
    p_start_needs_unlock_r5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(q.wr_go) |-> $past(armed));
    // R7: no write ever runs with program space selected
    p_no_prog_write_r7: assert property (@(posedge clk) disable iff (!por_n)
        q.wr_go |-> !q.space);
    // R8: write timer stays inside its window
    p_wr_window_r8: assert property (@(posedge clk) disable iff (!por_n)
        q.wr_go |-> (q.cnt < CNT_W'(WR_CYCLES)));
    // R8: normal completion raises the done flag
    p_done_on_finish_r8: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(q.wr_go) && $past(warm_rst_n) && $past(por_n)) |-> q.done);
    // R12: a warm reset that cuts a write leaves the error flag
    p_err_on_cut_r12: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(q.wr_go) && !$past(warm_rst_n) && $past(por_n)) |-> q.err);
    // R3: read-start is a one-cycle pulse
    p_read_pulse_r3: assert property (@(posedge clk) disable iff (!por_n)
        q.rd_go |=> !q.rd_go);
    // R10: address held while a write runs
    p_addr_held_r10: assert property (@(posedge clk) disable iff (!por_n)
        (q.wr_go && warm_rst_n) |=> $stable(q.alo));
endmodule

// File: tb/tb_nvm_ctrl.sv
`timescale 1ns/100ps
module tb_nvm_ctrl;
    localparam int WRC = 5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_rst_n = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       done_irq;

    int n_chk = 0;
    int n_err = 0;
    string cur_req = "R2";
    bit mon_on = 1'b0;

    nvm_ctrl #(.WR_CYCLES(WRC)) dut (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .done_irq(done_irq)
    );

    always #2.5 clk = ~clk;

    // behavioural reference state
    int m_alo, m_ahi, m_dlo, m_dhi, m_ulk, m_cnt;
    bit m_space, m_wren, m_err, m_done, m_rd, m_wr;
    int m_mem [256];

    function automatic int pword(int a);
        return (a * 467 + 677) % 16384;
    endfunction

    function automatic int m_rdata(int a);
        case (a)
            0: return m_alo;
            1: return m_ahi;
            2: return m_dlo;
            3: return m_dhi;
            4: return (m_space << 7) | (m_done << 4) | (m_err << 3) | (m_wren << 2) | (m_wr << 1) | int'(m_rd);
            default: return 0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!por_n) begin
            m_alo = 0; m_ahi = 0; m_dlo = 0; m_dhi = 0; m_ulk = 0; m_cnt = 0;
            m_space = 0; m_wren = 0; m_err = 0; m_done = 0; m_rd = 0; m_wr = 0;
        end else if (!warm_rst_n) begin
            m_err = m_err | m_wr;
            m_space = 0; m_wren = 0; m_done = 0; m_rd = 0; m_wr = 0; m_cnt = 0; m_ulk = 0;
        end else if (m_wr) begin
            m_ulk = 0;
            if (m_cnt == WRC - 1) begin
                m_mem[m_alo] = m_dlo; m_wr = 0; m_done = 1; m_cnt = 0;
            end else m_cnt++;
        end else if (m_rd) begin
            m_ulk = 0;
            m_rd = 0;
            if (m_space) begin
                m_dlo = pword(m_ahi * 256 + m_alo) % 256;
                m_dhi = pword(m_ahi * 256 + m_alo) / 256;
            end else m_dlo = m_mem[m_alo];
        end else if (bus_we) begin
            case (int'(bus_addr))
                0: m_alo = bus_wdata;
                1: m_ahi = bus_wdata % 16;
                2: m_dlo = bus_wdata;
                3: m_dhi = bus_wdata % 64;
                4: begin
                    m_space = bus_wdata[7]; m_wren = bus_wdata[2];
                    m_err = bus_wdata[3]; m_done = bus_wdata[4];
                    if (m_ulk == 2 && bus_wdata[1] && bus_wdata[2] && !bus_wdata[7]) begin
                        m_wr = 1; m_cnt = 0; m_mem[m_alo] = 255;
                    end else m_rd = bus_wdata[0];
                end
                default: ;
            endcase
            if (bus_addr == 3'd5 && bus_wdata == 8'h55) m_ulk = 1;
            else if (bus_addr == 3'd5 && bus_wdata == 8'hAA && m_ulk == 1) m_ulk = 2;
            else m_ulk = 0;
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            check(bus_rdata == 8'(m_rdata(int'(bus_addr))), {cur_req, " monitor rdata"},
                  int'(bus_rdata), m_rdata(int'(bus_addr)));
            check(done_irq == m_done, "R8 monitor done_irq", int'(done_irq), int'(m_done));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input int exp, input string tag);
        bus_addr = a;
        #0.5;
        check(bus_rdata == 8'(exp), tag, int'(bus_rdata), exp);
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(3'd5, 8'h55);
        wr(3'd5, 8'hAA);
    endtask

    task automatic wait_write(input string tag);
        int n = 0;
        bus_addr = 3'd4;
        #0.5;
        while (bus_rdata[1] && n < 100) begin
            n++;
            @(negedge clk);
            #0.5;
        end
        check(n == WRC, tag, n, WRC);
        @(negedge clk);
    endtask

    task automatic read_op(input logic [7:0] ctl);
        wr(3'd4, ctl);
        @(negedge clk);
    endtask

    task automatic warm_pulse();
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        mon_on = 1'b1;
        // R2 reset state
        cur_req = "R2";
        for (int a = 0; a < 8; a++) chk_reg(3'(a), 0, "R2 reset register");
        check(done_irq == 1'b0, "R2 done_irq after reset", int'(done_irq), 0);

        // R1 register map and masks
        cur_req = "R1";
        wr(3'd1, 8'hFF); chk_reg(3'd1, 8'h0F, "R1 addr high mask");
        wr(3'd3, 8'hFF); chk_reg(3'd3, 8'h3F, "R1 data high mask");
        wr(3'd5, 8'h55); chk_reg(3'd5, 0, "R1 unlock reads zero");
        wr(3'd4, 8'h64); chk_reg(3'd4, 8'h04, "R1 control unused bits read zero");
        wr(3'd1, 8'h00); wr(3'd4, 8'h00);

        // R5 R8 R9 basic write
        cur_req = "R8";
        wr(3'd0, 8'h3C); wr(3'd2, 8'hA5);
        unlock();
        wr(3'd4, 8'h06);
        wait_write("R8 write-start duration");
        chk_reg(3'd4, 8'h14, "R8 done set, write-start clear");
        repeat (4) @(negedge clk);
        check(done_irq == 1'b1, "R11 done sticky", int'(done_irq), 1);
        wr(3'd2, 8'h00);
        cur_req = "R3";
        wr(3'd3, 8'h2A);
        read_op(8'h01);
        chk_reg(3'd2, 8'hA5, "R9 stored byte read back");
        chk_reg(3'd3, 8'h2A, "R3 data high unchanged by data read");
        chk_reg(3'd4, 8'h00, "R11 done cleared by control write");

        // R12 warm reset mid-write leaves erased byte and error
        cur_req = "R12";
        wr(3'd2, 8'h5A);
        unlock();
        wr(3'd4, 8'h06);
        @(negedge clk);
        warm_pulse();
        chk_reg(3'd4, 8'h08, "R12 error set, other control clear");
        chk_reg(3'd0, 8'h3C, "R12 address kept");
        chk_reg(3'd2, 8'h5A, "R12 data kept");
        check(done_irq == 1'b0, "R12 no done after cut write", int'(done_irq), 0);
        read_op(8'h09);
        chk_reg(3'd2, 8'hFF, "R9 erased byte after cut write");
        chk_reg(3'd4, 8'h08, "R11 error persists");
        // retry
        wr(3'd2, 8'h5A);
        unlock();
        wr(3'd4, 8'h0E);
        wait_write("R12 retry duration");
        wr(3'd2, 8'h00);
        read_op(8'h01);
        chk_reg(3'd2, 8'h5A, "R12 retry stored");

        // R6 missing write-enable
        cur_req = "R6";
        unlock();
        wr(3'd4, 8'h02);
        chk_reg(3'd4, 8'h00, "R6 no start without enable");
        wr(3'd2, 8'h00);
        read_op(8'h01);
        chk_reg(3'd2, 8'h5A, "R6 byte unchanged");

        // R5 broken sequences
        cur_req = "R5";
        wr(3'd2, 8'h11);
        wr(3'd5, 8'h55); wr(3'd0, 8'h3C); wr(3'd5, 8'hAA); wr(3'd4, 8'h06);
        chk_reg(3'd4, 8'h04, "R5 interleaved write aborts");
        wr(3'd5, 8'hAA); wr(3'd5, 8'h55); wr(3'd4, 8'h06);
        chk_reg(3'd4, 8'h04, "R5 wrong order aborts");
        unlock(); wr(3'd2, 8'h11); wr(3'd4, 8'h06);
        chk_reg(3'd4, 8'h04, "R5 gap write aborts");
        read_op(8'h01);
        chk_reg(3'd2, 8'h5A, "R5 byte unchanged after aborts");

        // R7 write request in program space
        cur_req = "R7";
        wr(3'd1, 8'h01); wr(3'd0, 8'h23);
        unlock();
        wr(3'd4, 8'h86);
        chk_reg(3'd4, 8'h84, "R7 no start in program space");
        read_op(8'h81);
        chk_reg(3'd2, pword(12'h123) % 256, "R7 program low intact");
        chk_reg(3'd3, pword(12'h123) / 256, "R7 program high intact");

        // R4 program reads at edges
        cur_req = "R4";
        wr(3'd1, 8'h00); wr(3'd0, 8'h00); read_op(8'h81);
        chk_reg(3'd2, pword(0) % 256, "R4 word 0 low");
        chk_reg(3'd3, pword(0) / 256, "R4 word 0 high");
        wr(3'd1, 8'h0F); wr(3'd0, 8'hFF); read_op(8'h81);
        chk_reg(3'd2, pword(4095) % 256, "R4 last word low");
        chk_reg(3'd3, pword(4095) / 256, "R4 last word high");
        wr(3'd1, 8'h00); wr(3'd4, 8'h00);

        // R10 bus writes ignored while busy
        cur_req = "R10";
        wr(3'd0, 8'h40); wr(3'd2, 8'h77);
        unlock();
        wr(3'd4, 8'h06);
        wr(3'd0, 8'h11); wr(3'd2, 8'h22); wr(3'd4, 8'h01);
        @(negedge clk); @(negedge clk);
        chk_reg(3'd0, 8'h40, "R10 address ignored during write");
        chk_reg(3'd2, 8'h77, "R10 data ignored during write");
        wr(3'd2, 8'h00);
        read_op(8'h01);
        chk_reg(3'd2, 8'h77, "R10 byte written despite bus traffic");
        wr(3'd4, 8'h01);
        wr(3'd4, 8'h80);
        chk_reg(3'd4, 8'h00, "R10 control write ignored during read");

        // R13 warm reset while idle
        cur_req = "R13";
        wr(3'd0, 8'h9C); wr(3'd2, 8'h3E); wr(3'd4, 8'h1C);
        warm_pulse();
        chk_reg(3'd4, 8'h08, "R13 error kept, rest cleared");
        chk_reg(3'd0, 8'h9C, "R13 address kept");
        chk_reg(3'd2, 8'h3E, "R13 data kept");

        // R2 power-on clears everything
        cur_req = "R2";
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        chk_reg(3'd4, 8'h00, "R2 control after power-on");
        chk_reg(3'd0, 8'h00, "R2 address after power-on");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule